// File: doc/BRIEF.md
# NAND Flash Cycle Sequencer

This block turns encoded 32-bit operation words into pin-level cycles on an 8-bit NAND flash device. Software writes each word into a small queue through a register port. The sequencer takes the words in the order they were written and drives chip enable, the command and address latch enables, the write and read strobes and the data bus. It also watches the ready/busy line.

Each word selects one of four cycle kinds. Command and address words carry the byte to place on the bus. Data write and data read words carry a byte count, and their bytes move over two byte-wide stream ports. Flags in the word ask the sequencer to hold completion until the flash reports ready, to release chip enable after this word, and to raise an interrupt when the word finishes. A status register records completions and errors, and software clears its bits by writing ones. A write word whose data stream stays empty for too long is abandoned: the sequencer flags an error and discards every queued word.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset, chip enable, both strobes and `irq` are inactive. CLE, ALE and the bus output enable are low, and the status register reads zero.
- R2: Bits 17:16 of a word choose the cycle: 0 drives ALE, 1 drives CLE, 2 is a data write and 3 is a data read. For command and address cycles, bits 7:0 go onto the bus during one write-strobe pulse. CLE and ALE are never high together.
- R3: Words written to register offset 0x000 are queued and run strictly in the order they were written.
- R4: When bit 19 of a word is set, command-done is not reported while R/B# is low. It is reported only after R/B# returns high.
- R5: Status reads at offset 0x118, with command done at bit 9, write finished at bit 6, read finished at bit 7 and command error at bit 11. Writing a 1 at offset 0x120 clears the status bit in that position. Command done sets right after a word's last strobe cycle, or after the ready wait.
- R6: Chip enable stays low from the first word up to the completion of a word with bit 18 set. At that point it goes high, and it does not go high between earlier words.
- R7: Each strobe stays low for max(2, `strobe_clks`) clocks and then high for the same number of clocks.
- R8: A data write word moves (bits 11:0)+1 bytes. Each byte is taken from the write stream and then driven with one write-strobe pulse, and bit 6 sets on completion.
- R9: A data read word moves (bits 11:0)+1 bytes. Each byte is sampled at the end of the read-strobe low time and presented for one clock on the read stream, and bit 7 sets on completion.
- R10: If a data write waits `TIMEOUT` clocks with no stream byte, status bit 11 sets, all queued words are dropped, no further strobes occur and chip enable goes high.
- R11: A word with bit 13 set raises `irq` on completion, and writing a 1 to bit 9 at offset 0x120 lowers it. A word without bit 13 leaves `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (status at 0x118) |
| strobe_clks | input | TW | Strobe low/high width in clocks (minimum 2) |
| irq | output | 1 | Completion interrupt |
| wr_valid | input | 1 | Write-stream byte valid |
| wr_data | input | 8 | Write-stream byte |
| wr_ready | output | 1 | Write-stream byte accepted |
| rd_valid | output | 1 | Read-stream byte valid |
| rd_data | output | 8 | Read-stream byte |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_dq_out | output | 8 | Bus value driven to flash |
| fl_dq_oe | output | 1 | Bus output enable |
| fl_dq_in | input | 8 | Bus value from flash |
| fl_rb_n | input | 1 | Ready (high) / busy (low) |

## Verification
The embedded assertions check these rules on every clock:
- CLE and ALE are never both high.
- A strobe is only active while chip enable is low.
- The bus is never driven during a read strobe.
- A strobe never lasts a single clock.
- An accepted write byte is followed at once by a write strobe.
- Command-done never rises while the ready wait sees busy.
- The queue is empty whenever an error is flagged.

The bench scenarios show what needs whole sequences:
- the bytes and latch enables in queue order;
- the exact strobe width for a programmed count and for a count below the minimum;
- chip enable held across unterminated words;
- read data delivery;
- the interrupt set and clear;
- the absence of any bus activity after a timeout flush.

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq #(
  parameter int DEPTH   = 4,
  parameter int TIMEOUT = 256,
  parameter int LEN_W   = 12,
  parameter int TW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [11:0]   reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [TW-1:0] strobe_clks,
  output logic          irq,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  output logic          wr_ready,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic          fl_ce_n,
  output logic          fl_cle,
  output logic          fl_ale,
  output logic          fl_we_n,
  output logic          fl_re_n,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in,
  input  logic          fl_rb_n
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = AW + 1;
  localparam int EW  = LEN_W + 5;
  localparam int TOW = $clog2(TIMEOUT + 1);
  localparam logic [11:0] OFS_QUEUE = 12'h000;
  localparam logic [11:0] OFS_STAT  = 12'h118;
  localparam logic [11:0] OFS_CLEAR = 12'h120;

  typedef enum logic [2:0] {S_IDLE, S_WDATA, S_LOW, S_HIGH, S_RB, S_DONE} st_t;

  st_t              st;
  logic [EW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic [1:0]       c_type;
  logic             c_wfr, c_lc, c_iwc;
  logic [7:0]       c_byte, dbyte;
  logic [LEN_W-1:0] bcnt;
  logic [TW-1:0]    tcnt;
  logic [TOW-1:0]   tocnt;
  logic [12:0]      stat;
  logic             ce_hold;

  wire unused_wbits = ^{reg_wdata[31:20], reg_wdata[15:14]};

  wire [TW-1:0] tw      = (strobe_clks < TW'(2)) ? TW'(2) : strobe_clks;
  wire          is_rd   = (c_type == 2'd3);
  wire          is_data = c_type[1];
  wire          active  = (st == S_LOW) || (st == S_HIGH);
  wire          err_set = (st == S_WDATA) && !wr_valid && (tocnt == TOW'(TIMEOUT - 1));
  wire          done_set = (st == S_DONE);
  wire          full    = (cnt == CW'(DEPTH));
  wire          push    = reg_we && (reg_addr == OFS_QUEUE) && !full && !err_set;
  wire          pop     = (st == S_IDLE) && (cnt != '0);
  wire [EW-1:0] head    = mem[rp];
  wire [12:0]   stat_clr = (reg_we && reg_addr == OFS_CLEAR) ? reg_wdata[12:0] : 13'd0;

  logic [12:0] stat_set;
  always_comb begin
    stat_set     = '0;
    stat_set[9]  = done_set;
    stat_set[6]  = done_set && (c_type == 2'd2);
    stat_set[7]  = done_set && (c_type == 2'd3);
    stat_set[11] = err_set;
  end

  assign reg_rdata = (reg_addr == OFS_STAT) ? {19'd0, stat} : 32'd0;
  assign wr_ready  = (st == S_WDATA);
  assign fl_ce_n   = !((st != S_IDLE) || ce_hold);
  assign fl_we_n   = !((st == S_LOW) && !is_rd);
  assign fl_re_n   = !((st == S_LOW) && is_rd);
  assign fl_cle    = active && (c_type == 2'd1);
  assign fl_ale    = active && (c_type == 2'd0);
  assign fl_dq_oe  = active && !is_rd;
  assign fl_dq_out = is_data ? dbyte : c_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else if (err_set) begin
      rp <= wp;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      if (push && !pop)      cnt <= cnt + CW'(1);
      else if (pop && !push) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {reg_wdata[19], reg_wdata[18], reg_wdata[13],
                          reg_wdata[17:16], reg_wdata[LEN_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      c_type <= 2'd0;
      c_wfr <= 1'b0;
      c_lc <= 1'b0;
      c_iwc <= 1'b0;
      c_byte <= '0;
      dbyte <= '0;
      bcnt <= '0;
      tcnt <= '0;
      tocnt <= '0;
      stat <= '0;
      irq <= 1'b0;
      ce_hold <= 1'b0;
      rd_valid <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_valid <= 1'b0;
      stat <= (stat & ~stat_clr) | stat_set;
      if (done_set && c_iwc) irq <= 1'b1;
      else if (stat_clr[9])  irq <= 1'b0;
      case (st)
        S_IDLE: if (pop) begin
          c_wfr  <= head[EW-1];
          c_lc   <= head[EW-2];
          c_iwc  <= head[EW-3];
          c_type <= head[LEN_W+1:LEN_W];
          c_byte <= head[7:0];
          bcnt   <= head[LEN_W-1:0];
          tocnt  <= '0;
          tcnt   <= tw - TW'(1);
          st     <= (head[LEN_W+1:LEN_W] == 2'd2) ? S_WDATA : S_LOW;
        end
        S_WDATA: begin
          if (wr_valid) begin
            dbyte <= wr_data;
            tocnt <= '0;
            tcnt  <= tw - TW'(1);
            st    <= S_LOW;
          end else if (err_set) begin
            ce_hold <= 1'b0;
            st      <= S_IDLE;
          end else begin
            tocnt <= tocnt + TOW'(1);
          end
        end
        S_LOW: begin
          if (tcnt == '0) begin
            if (is_rd) begin
              rd_valid <= 1'b1;
              rd_data  <= fl_dq_in;
            end
            tcnt <= tw - TW'(1);
            st   <= S_HIGH;
          end else begin
            tcnt <= tcnt - TW'(1);
          end
        end
        S_HIGH: begin
          if (tcnt != '0) begin
            tcnt <= tcnt - TW'(1);
          end else if (is_data && bcnt != '0) begin
            bcnt <= bcnt - LEN_W'(1);
            tcnt <= tw - TW'(1);
            st   <= is_rd ? S_LOW : S_WDATA;
          end else begin
            st <= c_wfr ? S_RB : S_DONE;
          end
        end
        S_RB: if (fl_rb_n) st <= S_DONE;
        S_DONE: begin
          ce_hold <= !c_lc;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_cle && fl_ale));
  a_r6_strobe_under_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || !fl_re_n) |-> !fl_ce_n);
  a_r9_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_re_n |-> !fl_dq_oe);
  a_r7_we_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |=> !fl_we_n);
  a_r7_re_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_re_n) |=> !fl_re_n);
  a_r8_byte_then_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && wr_valid) |=> !fl_we_n);
  a_r4_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RB && !fl_rb_n) |=> !$rose(stat[9]));
  a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[11]) |-> (cnt == '0));
endmodule

// File: tb/tb_nand_cycle_seq.sv
module tb_nand_cycle_seq;
  localparam int TW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [TW-1:0] strobe_clks = 4'd2;
  logic          irq;
  logic          wr_valid = 1'b0;
  logic [7:0]    wr_data = '0;
  logic          wr_ready;
  logic          rd_valid;
  logic [7:0]    rd_data;
  logic          fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
  logic [7:0]    fl_dq_out;
  logic [7:0]    fl_dq_in = '0;
  logic          fl_rb_n = 1'b1;

  nand_cycle_seq #(.TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .strobe_clks(strobe_clks),
    .irq(irq), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .fl_ce_n(fl_ce_n), .fl_cle(fl_cle),
    .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_rb_n(fl_rb_n));

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  logic [9:0] exp_bus[$];
  logic [7:0] exp_rd[$];
  logic [9:0] bus_e;
  logic [7:0] rd_e;
  logic [7:0] rpat = 8'h21;
  int weps = 0, lowcnt = 0, last_low = 0, ce_rises = 0, rd_seen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_en && !fl_we_n) lowcnt++;

  always @(posedge fl_we_n) if (mon_en) begin
    weps++;
    last_low = lowcnt;
    lowcnt = 0;
    if (exp_bus.size() == 0)
      chk(1'b0, "R2 unexpected bus cycle", {fl_cle, fl_ale, fl_dq_out}, 0);
    else begin
      bus_e = exp_bus.pop_front();
      chk({fl_cle, fl_ale, fl_dq_out} == bus_e, "R2 R3 R8 bus cycle",
          {fl_cle, fl_ale, fl_dq_out}, bus_e);
    end
  end

  always @(posedge fl_we_n) if (mon_en && fl_cle) begin
    fl_rb_n = 1'b0;
    repeat (20) @(posedge clk);
    fl_rb_n = 1'b1;
  end

  always @(posedge fl_ce_n) if (mon_en) ce_rises++;

  always @(negedge fl_re_n) if (mon_en) begin
    fl_dq_in = rpat;
    exp_rd.push_back(rpat);
    rpat = rpat + 8'h13;
  end

  always @(negedge clk) if (mon_en && rd_valid) begin
    rd_seen++;
    if (exp_rd.size() == 0) chk(1'b0, "R9 unexpected read byte", rd_data, 0);
    else begin
      rd_e = exp_rd.pop_front();
      chk(rd_data == rd_e, "R9 read byte", rd_data, rd_e);
    end
  end

  function automatic logic [31:0] mk(input int ty, input bit wfr, input bit lc,
                                     input bit iwc, input int low);
    return (32'(wfr) << 19) | (32'(lc) << 18) | (32'(ty) << 16) |
           (32'(iwc) << 13) | (32'(low) & 32'hFFF);
  endfunction

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic stat_rd(output logic [31:0] d);
    @(negedge clk);
    reg_addr = 12'h118;
    #1 d = reg_rdata;
  endtask

  task automatic wait_bit(input int b, output bit ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int i = 0; i < 3000 && !ok; i++) begin
      stat_rd(s);
      ok = s[b];
    end
  endtask

  task automatic wait_ce_high();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (fl_ce_n) break;
    end
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s;
    bit ok;
    int c0, w0;
    repeat (3) @(negedge clk);
    chk(fl_ce_n == 1'b1, "R1 ce_n in reset", fl_ce_n, 1);
    chk(fl_we_n && fl_re_n, "R1 strobes in reset", {fl_we_n, fl_re_n}, 3);
    chk(!fl_cle && !fl_ale && !fl_dq_oe, "R1 latches in reset", {fl_cle, fl_ale, fl_dq_oe}, 0);
    chk(irq == 1'b0, "R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    stat_rd(s);
    chk(s == 32'd0, "R1 status after reset", s, 0);

    // command word with ready wait, last cycle and interrupt
    exp_bus.push_back({2'b10, 8'h70});
    reg_wr(12'h000, mk(1, 1, 1, 1, 'h70));
    @(posedge fl_we_n);
    repeat (8) @(negedge clk);
    stat_rd(s);
    chk(s[9] == 1'b0, "R4 done held while busy", s[9], 0);
    chk(irq == 1'b0, "R11 irq held while busy", irq, 0);
    wait_bit(9, ok);
    chk(ok, "R4 R5 done after ready", ok, 1);
    chk(fl_rb_n == 1'b1, "R4 done only once ready", fl_rb_n, 1);
    @(negedge clk);
    chk(irq == 1'b1, "R11 irq on completion", irq, 1);
    chk(fl_ce_n == 1'b1, "R6 ce released after last word", fl_ce_n, 1);
    reg_wr(12'h120, 32'h200);
    stat_rd(s);
    chk(s[9] == 1'b0, "R5 write-one clears done", s[9], 0);
    chk(irq == 1'b0, "R11 irq cleared", irq, 0);

    // address sequence: chip enable held across words
    c0 = ce_rises;
    exp_bus.push_back({2'b01, 8'h00});
    exp_bus.push_back({2'b01, 8'h5A});
    exp_bus.push_back({2'b01, 8'hC3});
    reg_wr(12'h000, mk(0, 0, 0, 0, 'h00));
    reg_wr(12'h000, mk(0, 0, 0, 0, 'h5A));
    reg_wr(12'h000, mk(0, 0, 1, 0, 'hC3));
    wait_ce_high();
    chk(ce_rises - c0 == 1, "R6 single ce release", ce_rises - c0, 1);
    chk(exp_bus.size() == 0, "R3 all address bytes in order", exp_bus.size(), 0);
    chk(irq == 1'b0, "R11 no irq without request", irq, 0);
    reg_wr(12'h120, 32'h1FFF);

    // data write, 5 bytes, strobe width 3
    strobe_clks = 4'd3;
    for (int i = 0; i < 5; i++) exp_bus.push_back({2'b00, 8'(8'hA0 + i * 7)});
    reg_wr(12'h000, mk(2, 0, 1, 1, 4));
    for (int i = 0; i < 5; i++) send_byte(8'(8'hA0 + i * 7));
    wait_bit(6, ok);
    chk(ok, "R8 write finished flag", ok, 1);
    stat_rd(s);
    chk(s[9] == 1'b1, "R5 done with write", s[9], 1);
    chk(last_low == 3, "R7 strobe low width", last_low, 3);
    chk(exp_bus.size() == 0, "R8 all write bytes", exp_bus.size(), 0);
    chk(irq == 1'b1, "R11 irq after write", irq, 1);
    reg_wr(12'h120, 32'h1FFF);

    // strobe count below minimum
    strobe_clks = 4'd0;
    exp_bus.push_back({2'b01, 8'h3C});
    reg_wr(12'h000, mk(0, 0, 1, 0, 'h3C));
    wait_ce_high();
    chk(last_low == 2, "R7 minimum strobe width", last_low, 2);
    reg_wr(12'h120, 32'h1FFF);

    // data read, 4 bytes, no interrupt
    strobe_clks = 4'd2;
    rd_seen = 0;
    reg_wr(12'h000, mk(3, 0, 1, 0, 3));
    wait_bit(7, ok);
    chk(ok, "R9 read finished flag", ok, 1);
    @(negedge clk);
    chk(rd_seen == 4, "R9 read byte count", rd_seen, 4);
    chk(irq == 1'b0, "R11 no irq on read", irq, 0);
    reg_wr(12'h120, 32'h1FFF);

    // timeout on empty write stream flushes the queue
    w0 = weps;
    reg_wr(12'h000, mk(2, 0, 0, 0, 1));
    reg_wr(12'h000, mk(1, 0, 1, 0, 'h90));
    reg_wr(12'h000, mk(0, 0, 1, 0, 'h05));
    wait_bit(11, ok);
    chk(ok, "R10 error flag", ok, 1);
    repeat (50) @(negedge clk);
    chk(weps == w0, "R10 no strobes after flush", weps - w0, 0);
    chk(fl_ce_n == 1'b1, "R10 ce released", fl_ce_n, 1);
    stat_rd(s);
    chk(s[9] == 1'b0, "R10 flushed words never complete", s[9], 0);
    reg_wr(12'h120, 32'h800);
    stat_rd(s);
    chk(s[11] == 1'b0, "R5 error cleared", s[11], 0);
    exp_bus.push_back({2'b10, 8'hFF});
    reg_wr(12'h000, mk(1, 0, 1, 0, 'hFF));
    wait_bit(9, ok);
    chk(ok, "R3 queue usable after flush", ok, 1);

    repeat (30) @(negedge clk);
    chk(exp_bus.size() == 0, "R2 scoreboard drained", exp_bus.size(), 0);
    chk(exp_rd.size() == 0, "R9 read scoreboard drained", exp_rd.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule